// File: doc/BRIEF.md
# Synthesizer Serial Programming Loader

This block receives divider settings for a frequency synthesizer over a three-wire serial link: a serial clock, a serial data line and a load strobe. It samples these three lines with the system clock. On each rising edge of the serial clock it shifts one data bit into a frame register, most significant bit first. When the load strobe is qualified, the two bits shifted in last select the destination. A reference-divider word or a comparator-divider word is copied into its own holding register. A valid flag marks each holding register once it has been written.

A comparator-side frame starts with a three-bit test field that must be all zeros. The loader raises an error flag when a comparator write carries a non-zero test field. The strobe is level qualified. A transfer happens only while the strobe is high and the serial clock and data lines are both low. A strobe that rises while either line is high waits until both lines drop. The frame register always keeps the newest 23 bits, so any extra leading bits fall off the front of the frame.

Top module: `synth_serial_loader`

## Requirements
- R1: Serial data is captured on each rising edge of `ser_clk` and shifted in most significant bit first. Falling edges and steady levels of `ser_clk` shift nothing.
- R2: When the two bits shifted in last are 1 then 1, a qualified load copies the 17 bits shifted in just before them into `ref_word`. The earliest of those 17 bits becomes bit 16.
- R3: When the two bits shifted in last are 0 then 1, a qualified load copies the 18 bits shifted in just before them into `cmp_word`. The earliest of those 18 bits becomes bit 17.
- R4: The control codes 0 then 0, and 1 then 0, change neither holding register nor either valid flag.
- R5: A load is qualified only while `ser_le` is high with `ser_clk` and `ser_data` both low. If either line is high while `ser_le` is high, nothing transfers until both lines are low.
- R6: While `ser_le` is low, shifting bits changes no output.
- R7: `ref_valid` and `cmp_valid` are low after reset. Each one rises with the first write to its own register and stays high until reset.
- R8: `prefix_err` takes, on every comparator write, the OR of the three bits shifted in just before the 18-bit word. It keeps its value across reference writes and ignored codes.
- R9: A reference write leaves `cmp_word` unchanged, and a comparator write leaves `ref_word` unchanged.
- R10: A synchronous reset clears both words, both valid flags and `prefix_err`.
- R11: Only the newest 23 shifted bits matter. Extra bits shifted in before a frame have no effect on the transferred word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe, active high |
| ref_word | output | 17 | Reference-divider holding register |
| ref_valid | output | 1 | Reference register has been written |
| cmp_word | output | 18 | Comparator-divider holding register |
| cmp_valid | output | 1 | Comparator register has been written |
| prefix_err | output | 1 | Last comparator frame had a non-zero test field |

## Verification
Some checks run on every cycle. The two write enables are never both active, and neither is active while the synchronized strobe is low. A holding register or the error flag changes only right after its own write enable. The valid flags rise only on a write and never fall outside reset. Other behaviour shows only in the bench scenarios, because it depends on the order of serial bits. These cover bit ordering and field alignment, rejection of the unused control codes, the deferral of a strobe raised while the clock or data line is high, and dropping of leading junk bits.

// File: rtl/synth_ld_pkg.sv
package synth_ld_pkg;

    localparam int REF_W  = 17;
    localparam int CMP_W  = 18;
    localparam int PFX_W  = 3;
    localparam int CTL_W  = 2;
    localparam int SR_W   = PFX_W + CMP_W + CTL_W;
    localparam int SYNC_N = 2;

    localparam logic [CTL_W-1:0] CTL_REF = 2'b11;
    localparam logic [CTL_W-1:0] CTL_CMP = 2'b01;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REF  = 2'd1,
        TGT_CMP  = 2'd2
    } target_e;

    typedef struct packed {
        logic [PFX_W-1:0] prefix;
        logic [CMP_W-1:0] word;
        logic [CTL_W-1:0] ctl;
    } frame_t;

    typedef struct packed {
        logic le;
        logic sclk;
        logic sdata;
    } serial_t;

    function automatic target_e decode_target(input logic [CTL_W-1:0] ctl);
        target_e t;
        case (ctl)
            CTL_REF: t = TGT_REF;
            CTL_CMP: t = TGT_CMP;
            default: t = TGT_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) st[0] <= '0;
                    else     st[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) st[g] <= '0;
                    else     st[g] <= st[g-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/sld_shifter.sv
module sld_shifter #(
    parameter int W = synth_ld_pkg::SR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= {q[W-2:0], bit_in};
    end
endmodule

// File: rtl/sld_decoder.sv
module sld_decoder
    import synth_ld_pkg::*;
(
    input  frame_t           frame,
    input  logic             load_ok,
    output logic             ref_we,
    output logic             cmp_we,
    output logic [REF_W-1:0] ref_d,
    output logic [CMP_W-1:0] cmp_d,
    output logic             prefix_bad
);
    target_e tgt;

    always_comb begin
        tgt        = decode_target(frame.ctl);
        ref_we     = load_ok && (tgt == TGT_REF);
        cmp_we     = load_ok && (tgt == TGT_CMP);
        ref_d      = frame.word[REF_W-1:0];
        cmp_d      = frame.word;
        prefix_bad = |frame.prefix;
    end
endmodule

// File: rtl/sld_hold.sv
module sld_hold #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            valid <= 1'b0;
        end else if (we) begin
            q     <= d;
            valid <= 1'b1;
        end
    end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
    import synth_ld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_le,
    output logic [REF_W-1:0] ref_word,
    output logic             ref_valid,
    output logic [CMP_W-1:0] cmp_word,
    output logic             cmp_valid,
    output logic             prefix_err
);
    serial_t          raw_s;
    serial_t          sync_s;
    logic             sclk_prev;
    logic             shift_en;
    logic             load_ok;
    logic [SR_W-1:0]  sr_q;
    frame_t           frame;
    logic             ref_we;
    logic             cmp_we;
    logic [REF_W-1:0] ref_d;
    logic [CMP_W-1:0] cmp_d;
    logic             prefix_bad;

    assign raw_s = '{le: ser_le, sclk: ser_clk, sdata: ser_data};

    sld_sync #(.W($bits(serial_t)), .STAGES(SYNC_N)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_s),
        .q   (sync_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sync_s.sclk;
    end

    assign shift_en = sync_s.sclk && !sclk_prev;
    assign load_ok  = sync_s.le && !sync_s.sclk && !sync_s.sdata;

    sld_shifter #(.W(SR_W)) i_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_in   (sync_s.sdata),
        .q        (sr_q)
    );

    assign frame = frame_t'(sr_q);

    sld_decoder i_dec (
        .frame      (frame),
        .load_ok    (load_ok),
        .ref_we     (ref_we),
        .cmp_we     (cmp_we),
        .ref_d      (ref_d),
        .cmp_d      (cmp_d),
        .prefix_bad (prefix_bad)
    );

    sld_hold #(.W(REF_W)) i_ref (
        .clk   (clk),
        .rst   (rst),
        .we    (ref_we),
        .d     (ref_d),
        .q     (ref_word),
        .valid (ref_valid)
    );

    sld_hold #(.W(CMP_W)) i_cmp (
        .clk   (clk),
        .rst   (rst),
        .we    (cmp_we),
        .d     (cmp_d),
        .q     (cmp_word),
        .valid (cmp_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)         prefix_err <= 1'b0;
        else if (cmp_we) prefix_err <= prefix_bad;
    end
endmodule

// File: rtl/sld_checker.sv
module sld_checker
    import synth_ld_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             le_sync,
    input logic             ref_we,
    input logic             cmp_we,
    input logic [REF_W-1:0] ref_word,
    input logic [CMP_W-1:0] cmp_word,
    input logic             ref_valid,
    input logic             cmp_valid,
    input logic             prefix_err
);
    assert_one_target_R4: assert property (@(posedge clk) disable iff (rst)
        !(ref_we && cmp_we));

    assert_no_strobe_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        !le_sync |-> (!ref_we && !cmp_we));

    assert_ref_change_R2: assert property (@(posedge clk) disable iff (rst)
        (ref_word != $past(ref_word)) |-> $past(ref_we));

    assert_cmp_change_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp_word != $past(cmp_word)) |-> $past(cmp_we));

    assert_ref_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> ref_valid);

    assert_cmp_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> cmp_valid);

    assert_ref_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_valid) |-> $past(ref_we));

    assert_cmp_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_valid) |-> $past(cmp_we));

    assert_err_update_R8: assert property (@(posedge clk) disable iff (rst)
        (prefix_err != $past(prefix_err)) |-> $past(cmp_we));
endmodule

bind synth_serial_loader sld_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .le_sync    (sync_s.le),
    .ref_we     (ref_we),
    .cmp_we     (cmp_we),
    .ref_word   (ref_word),
    .cmp_word   (cmp_word),
    .ref_valid  (ref_valid),
    .cmp_valid  (cmp_valid),
    .prefix_err (prefix_err)
);

// File: tb/test_synth_serial_loader.sv
module test_synth_serial_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_le = 1'b0;
    logic [16:0] ref_word;
    logic        ref_valid;
    logic [17:0] cmp_word;
    logic        cmp_valid;
    logic        prefix_err;

    always #2 clk = ~clk;

    synth_serial_loader i_synth_serial_loader (
        .clk        (clk),
        .rst        (rst),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_le     (ser_le),
        .ref_word   (ref_word),
        .ref_valid  (ref_valid),
        .cmp_word   (cmp_word),
        .cmp_valid  (cmp_valid),
        .prefix_err (prefix_err)
    );

    typedef struct {
        logic [16:0] r;
        logic        rv;
        logic [17:0] c;
        logic        cv;
        logic        e;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [16:0] m_ref = '0;
    logic        m_rv = 1'b0;
    logic [17:0] m_cmp = '0;
    logic        m_cv = 1'b0;
    logic        m_err = 1'b0;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        e.r = m_ref; e.rv = m_rv; e.c = m_cmp; e.cv = m_cv; e.e = m_err; e.tag = tag;
        sb.push_back(e);
        wait_clk(3);
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wait_clk(3);
            ser_clk = 1'b1;
            wait_clk(5);
            ser_clk = 1'b0;
            wait_clk(3);
        end
        ser_data = 1'b0;
        wait_clk(4);
    endtask

    task automatic pulse_le;
        ser_le = 1'b1;
        wait_clk(8);
        ser_le = 1'b0;
        wait_clk(8);
    endtask

    task automatic write_ref(input logic [16:0] w);
        shift_bits({13'd0, w, 2'b11}, 19);
        pulse_le();
        m_ref = w; m_rv = 1'b1;
    endtask

    task automatic write_cmp(input logic [2:0] p, input logic [17:0] w);
        shift_bits({9'd0, p, w, 2'b01}, 23);
        pulse_le();
        m_cmp = w; m_cv = 1'b1; m_err = (p != 3'b000);
    endtask

    // monitor: compares each queued expectation against the ports
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (ref_word !== e.r || ref_valid !== e.rv || cmp_word !== e.c ||
                    cmp_valid !== e.cv || prefix_err !== e.e) begin
                    n_fail++;
                    $display("FAIL %s: got ref=%h rv=%b cmp=%h cv=%b err=%b, expected ref=%h rv=%b cmp=%h cv=%b err=%b",
                             e.tag, ref_word, ref_valid, cmp_word, cmp_valid, prefix_err,
                             e.r, e.rv, e.c, e.cv, e.e);
                end
            end
        end
    end

    initial begin
        wait_clk(200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        expect_now("R10 R7 reset state");

        write_ref(17'h1A5C3);
        expect_now("R1 R2 R7 first reference write");

        write_cmp(3'b000, 18'h2B7E1);
        expect_now("R3 R9 R7 first comparator write");

        write_cmp(3'b101, 18'h0F0F5);
        expect_now("R8 non-zero test field flagged");

        shift_bits({9'd0, 3'b000, 18'h3FFFF, 2'b00}, 23);
        expect_now("R6 shifting without strobe holds outputs");
        pulse_le();
        expect_now("R4 code 00 ignored");

        shift_bits({9'd0, 3'b000, 18'h12345, 2'b10}, 23);
        pulse_le();
        expect_now("R4 code 10 ignored");

        write_ref(17'h00F01);
        expect_now("R8 R9 reference write keeps comparator side");

        shift_bits({7'd0, 5'b10110, 17'h15555, 2'b11}, 24);
        pulse_le();
        m_ref = 17'h15555;
        expect_now("R11 leading junk bits dropped");

        // R5: strobe raised while serial clock or data is high
        shift_bits({13'd0, 17'h0ABCD, 1'b1}, 18);
        ser_data = 1'b1;
        wait_clk(3);
        ser_clk = 1'b1;
        wait_clk(6);
        ser_le = 1'b1;
        wait_clk(8);
        expect_now("R5 strobe with clock and data high");
        ser_data = 1'b0;
        wait_clk(8);
        expect_now("R5 strobe with clock high");
        ser_data = 1'b1;
        wait_clk(3);
        ser_clk = 1'b0;
        wait_clk(8);
        expect_now("R5 strobe with data high");
        ser_data = 1'b0;
        wait_clk(8);
        m_ref = 17'h0ABCD;
        expect_now("R5 transfer once both lines low");
        ser_le = 1'b0;
        wait_clk(8);

        write_cmp(3'b000, 18'h20001);
        expect_now("R8 clean test field clears flag");

        write_cmp(3'b001, 18'h00000);
        expect_now("R3 R8 zero word with low prefix bit set");

        rst = 1'b1;
        wait_clk(3);
        m_ref = '0; m_rv = 1'b0; m_cmp = '0; m_cv = 1'b0; m_err = 1'b0;
        expect_now("R10 reset after writes");
        rst = 1'b0;
        wait_clk(4);

        write_cmp(3'b000, 18'h3C3C3);
        expect_now("R7 comparator valid alone after reset");

        wait_clk(10);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule